// File: doc/BRIEF.md
# Low-Power Down-Counting Timer with Underflow Interrupt

This block is a 16-bit down-counter for a low-power system chip. Software writes a start value over a simple register strobe, and the counter takes that value on the next clock edge. The counter then counts down on single-cycle tick enables that three counter-based prescalers derive from the one system clock. When the counter passes below zero it raises a sticky interrupt request. Software clears the request with a dedicated strobe. The current count can be read at any time on a readback bus without affecting counting.

Control inputs choose the tick source: a fast tick, a slow tick, or an alternate divide-by-26 tick that replaces the fast tick for this timer only. The raw fast and slow ticks are also driven out for other peripherals, and the alternate selection never alters them. A mode input chooses what happens at underflow. In free-running mode the counter wraps to all ones. In periodic mode it reloads the value written last. A second timer is made by instantiating the block again.

Top module: `lp_timer`

## Requirements
- R1: After reset the count reads 0 and the interrupt request is low.
- R2: A write strobe loads the written value into the counter, and the new value is visible on the readback bus in the cycle after the strobe.
- R3: After a write, the first selected tick does not change the count. Each selected tick after that decrements the count by one.
- R4: A selected tick that finds the count at 0, with the counter armed and no write in that cycle, sets the interrupt request in the following cycle.
- R5: The interrupt request stays high until a clear strobe arrives. A clear strobe in the same cycle as a new underflow leaves the request high.
- R6: With the periodic input low, an underflow wraps the count to 16'hFFFF.
- R7: With the periodic input high, an underflow reloads the value written last.
- R8: With the slow-select input high, the timer counts on the slow tick, one every LO_DIV system clocks. With it low, the timer counts on the fast tick, one every HI_DIV clocks.
- R9: With the slow-select input low and the alternate-enable input high, the timer counts on a tick every ALT_DIV clocks. The fast and slow tick outputs keep their own periods whatever the alternate-enable input is.
- R10: A write in the same cycle as a selected tick takes priority over that tick, and the two-tick start delay restarts from the write.
- R11: The count changes only in a cycle that holds a write strobe or a selected tick, so reading it never disturbs it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the count register |
| wr_data | input | 16 | Value to load |
| src_lo | input | 1 | 1 selects the slow tick, 0 selects the fast or alternate tick |
| alt_en | input | 1 | 1 replaces the fast tick with the divide-by-ALT_DIV tick |
| periodic | input | 1 | 1 reloads on underflow, 0 wraps to all ones |
| irq_clr | input | 1 | Clears the interrupt request |
| rd_data | output | 16 | Current count |
| irq | output | 1 | Sticky underflow interrupt request |
| hi_tick | output | 1 | Raw fast tick enable for other peripherals |
| lo_tick | output | 1 | Raw slow tick enable for other peripherals |

## Verification
The bench builds the block with HI_DIV=4, LO_DIV=20 and ALT_DIV=7 in place of the long real-rate divisors. With these values, full underflow and reload sequences, source switches and exact tick spacing each take only tens of cycles. Because the three divisors are distinct, a timer counting on the wrong source drifts away from the model within a few ticks. Directed phases place a write and a clear strobe on the exact cycle of a tick to reach the priority corners.

// File: rtl/lp_timer_pkg.sv
package lp_timer_pkg;
    parameter int CNT_W = 16;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] reload;
        logic             armed;
        logic             irq;
    } tmr_state_t;
endpackage

// File: rtl/tick_div.sv
module tick_div #(
    parameter int DIV = 26
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = (cnt_q == LAST);
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import lp_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             periodic,
    input  logic             irq_clr,
    output logic [CNT_W-1:0] count,
    output logic             irq
);
    tmr_state_t st_d, st_q;
    logic       under;

    always_comb begin
        st_d  = st_q;
        under = tick && st_q.armed && !wr_en && (st_q.count == '0);
        if (wr_en) begin
            st_d.count  = wr_data;
            st_d.reload = wr_data;
            st_d.armed  = 1'b0;
        end else if (tick) begin
            if (!st_q.armed)         st_d.armed = 1'b1;
            else if (under)          st_d.count = periodic ? st_q.reload : '1;
            else                     st_d.count = st_q.count - 1'b1;
        end
        st_d.irq = under || (st_q.irq && !irq_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.count;
    assign irq   = st_q.irq;
endmodule

// File: rtl/lp_timer.sv
module lp_timer
    import lp_timer_pkg::*;
#(
    parameter int HI_DIV  = 36,
    parameter int LO_DIV  = 9216,
    parameter int ALT_DIV = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             src_lo,
    input  logic             alt_en,
    input  logic             periodic,
    input  logic             irq_clr,
    output logic [CNT_W-1:0] rd_data,
    output logic             irq,
    output logic             hi_tick,
    output logic             lo_tick
);
    localparam int NSRC = 3;
    localparam int DIV_TAB [NSRC] = '{HI_DIV, LO_DIV, ALT_DIV};

    logic [NSRC-1:0] ticks;
    logic            sel_tick;

    for (genvar i = 0; i < NSRC; i++) begin : g_div
        tick_div #(.DIV(DIV_TAB[i])) u_div (
            .clk  (clk),
            .rst_n(rst_n),
            .tick (ticks[i])
        );
    end

    always_comb begin
        if (src_lo)      sel_tick = ticks[1];
        else if (alt_en) sel_tick = ticks[2];
        else             sel_tick = ticks[0];
    end

    tmr_core u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (sel_tick),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .periodic(periodic),
        .irq_clr (irq_clr),
        .count   (rd_data),
        .irq     (irq)
    );

    assign hi_tick = ticks[0];
    assign lo_tick = ticks[1];
endmodule

// File: rtl/lp_timer_chk.sv
module lp_timer_chk
    import lp_timer_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [CNT_W-1:0] wr_data,
    input logic             irq_clr,
    input logic             tick,
    input logic [CNT_W-1:0] rd_data,
    input logic             irq
);
    // R2
    load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data == $past(wr_data));

    // R3
    first_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en ##1 (!wr_en && tick) |=> $stable(rd_data));

    // R4
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(rd_data) == '0) && $past(tick) && !$past(wr_en));

    // R5
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);

    // R11
    count_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !tick) |=> $stable(rd_data));
endmodule

bind lp_timer lp_timer_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_data(wr_data),
    .irq_clr(irq_clr),
    .tick   (sel_tick),
    .rd_data(rd_data),
    .irq    (irq)
);

// File: tb/lp_timer_tb.sv
`timescale 1ns/1ps
module lp_timer_tb;
    localparam int HI = 4;
    localparam int LO = 20;
    localparam int AL = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        src_lo = 1'b0;
    logic        alt_en = 1'b0;
    logic        periodic = 1'b0;
    logic        irq_clr = 1'b0;
    logic [15:0] rd_data;
    logic        irq, hi_tick, lo_tick;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    // behavioural model
    longint      m_cyc = 0;
    int          m_cnt = 0;
    int          m_rel = 0;
    bit          m_arm = 0;
    bit          m_irq = 0;
    bit          m_hi, m_lo, m_al, m_sel;

    always #2.5 clk = ~clk;

    lp_timer #(.HI_DIV(HI), .LO_DIV(LO), .ALT_DIV(AL)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .src_lo(src_lo), .alt_en(alt_en), .periodic(periodic),
        .irq_clr(irq_clr), .rd_data(rd_data), .irq(irq),
        .hi_tick(hi_tick), .lo_tick(lo_tick)
    );

    always_comb begin
        m_hi  = (m_cyc % HI) == HI - 1;
        m_lo  = (m_cyc % LO) == LO - 1;
        m_al  = (m_cyc % AL) == AL - 1;
        m_sel = src_lo ? m_lo : (alt_en ? m_al : m_hi);
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cyc = 0; m_cnt = 0; m_rel = 0; m_arm = 0; m_irq = 0;
        end else begin
            bit uf;
            uf = m_sel && m_arm && !wr_en && m_cnt == 0;
            m_irq = uf || (m_irq && !irq_clr);
            if (wr_en) begin
                m_cnt = wr_data; m_rel = wr_data; m_arm = 0;
            end else if (m_sel) begin
                if (!m_arm) m_arm = 1;
                else if (m_cnt == 0) m_cnt = periodic ? m_rel : 16'hFFFF;
                else m_cnt = m_cnt - 1;
            end
            m_cyc = m_cyc + 1;
        end
    end

    task automatic check(string req, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            check("R11 count", rd_data, m_cnt);
            check("R4 irq", irq, m_irq);
            check("R9 hi_tick", hi_tick, m_hi);
            check("R8 lo_tick", lo_tick, m_lo);
        end
        if (cycles > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below 150000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic wr(input logic [15:0] v);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic next_tick();
        while (!m_sel) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 count", rd_data, 0);
        check("R1 irq", irq, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 / R3 / R4 / R6 free-running on fast tick
        wr(16'd3);
        check("R2 load", rd_data, 3);
        next_tick(); check("R3 hold", rd_data, 3);
        next_tick(); check("R3 dec", rd_data, 2);
        next_tick(); next_tick(); check("R3 dec", rd_data, 0);
        next_tick();
        check("R4 irq set", irq, 1);
        check("R6 wrap", rd_data, 16'hFFFF);
        repeat (3) @(negedge clk);
        check("R5 sticky", irq, 1);
        while (m_sel) @(negedge clk);
        irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
        check("R5 clear", irq, 0);

        // R7 periodic reload
        periodic = 1'b1;
        wr(16'd1);
        next_tick(); next_tick(); check("R7 to zero", rd_data, 0);
        next_tick();
        check("R7 reload", rd_data, 1);
        check("R7 irq", irq, 1);

        // R5 clear colliding with underflow
        periodic = 1'b0;
        wr(16'd0);
        next_tick();
        while (!m_sel) @(negedge clk);
        irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
        check("R5 collide", irq, 1);
        check("R6 wrap", rd_data, 16'hFFFF);

        // R10 write on a tick cycle
        while (!m_sel) @(negedge clk);
        wr(16'd10);
        check("R10 load", rd_data, 10);
        next_tick(); check("R10 restart", rd_data, 10);
        next_tick(); check("R10 dec", rd_data, 9);

        // R8 slow tick spacing
        src_lo = 1'b1;
        wr(16'd5);
        next_tick();
        for (int i = 0; i < LO - 1; i++) begin
            @(negedge clk); check("R8 slow hold", rd_data, 5);
        end
        @(negedge clk); check("R8 slow dec", rd_data, 4);

        // R9 alternate tick spacing
        src_lo = 1'b0; alt_en = 1'b1;
        wr(16'd8);
        next_tick();
        for (int i = 0; i < AL - 1; i++) begin
            @(negedge clk); check("R9 alt hold", rd_data, 8);
        end
        @(negedge clk); check("R9 alt dec", rd_data, 7);
        repeat (60) @(negedge clk);
        alt_en = 1'b0;
        repeat (20) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule